// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block performs 32-bit integer multiplication and division for a small embedded processor core. A request presents two 32-bit operands together with a 2-bit operation code on a single-cycle start strobe. The unit returns a 64-bit result split across a high word and a low word, together with a one-cycle completion pulse. While an operation is in flight, a busy flag is raised and further start requests are dropped.

Multiplication runs on a 32-by-16 partial-product array. When the second operand fits in 16 bits, the product is ready one cycle after the request, so such multiplies can be issued every cycle. A full-width second operand needs two passes through the array, with the upper-half partial product added to the lower one on the second pass. Division is a restoring shift-and-subtract loop over operand magnitudes. Before the loop starts, the dividend is aligned so that redundant leading bits are never iterated. The completion time of a divide therefore follows the size of the dividend.

Top module: `mdu_iter`

## Requirements
- R1: Op code 0 is signed multiply and op code 1 is unsigned multiply; on completion {hi_o, lo_o} holds the full 64-bit product of opa_i and opb_i, with both operands taken as two's complement for op 0 and as unsigned for op 1.
- R2: A multiply whose opb_i fits in 16 bits (unsigned: bits 31..16 all zero; signed: bits 31..15 all equal) raises done_o in the cycle after the start cycle and never raises busy_o, so such multiplies may be started in consecutive cycles.
- R3: A multiply whose opb_i does not fit in 16 bits holds busy_o high for exactly one cycle and raises done_o two cycles after the start cycle.
- R4: Op code 2 is signed divide and op code 3 is unsigned divide; lo_o receives the quotient truncated toward zero and hi_o the remainder, which carries the sign of the dividend (opa_i).
- R5: A divide raises done_o exactly 2 + max(9, n) cycles after its start cycle, where n is the bit length of opa_i (of its magnitude for a signed divide), giving 11 cycles at minimum and 34 for a 32-bit dividend.
- R6: busy_o is high in every cycle from the one after the start of a multi-cycle operation up to, but not including, its done cycle, and busy_o is low whenever done_o is high.
- R7: A start_i request in a cycle where busy_o is high is ignored; it causes no extra done_o pulse and does not alter the result of the running operation.
- R8: A divide with opb_i equal to zero completes with the normal R5 latency, and the unit then accepts and correctly completes the next operation.
- R9: done_o is high for one cycle per completed operation, and hi_o/lo_o change only in a cycle where done_o is high; otherwise they hold their last value.
- R10: While rst_n is low, busy_o and done_o are low and hi_o and lo_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start_i | input | 1 | Request strobe, accepted when busy_o is low |
| op_i | input | 2 | Operation: 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa_i | input | 32 | First operand (multiplicand or dividend) |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Multi-cycle operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper product word, or remainder |
| lo_o | output | 32 | Lower product word, or quotient |

## Verification
The bench builds the unit with its default widths (32-bit operands, 16-bit array half, at least nine divide iterations). With these values the whole divide latency range from 11 to 34 cycles is reachable. Dividends are chosen to land on the floor, just above it, at an intermediate width and at full width. The 16-bit array boundary is exercised in both directions, including a signed multiplier of 0x0000FFFF that looks narrow but needs two passes and the value -32768 that fits in one. Divides cover all four sign combinations, the most-negative dividend over -1, and a zero divisor.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } mdu_op_e;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIX  = 2'd2
  } dv_state_e;

endpackage

// File: rtl/mdu_mul_array.sv
// Signed-capable AW x BW partial-product array; each operand carries an
// extra sign bit selected by its *_sgn input.
module mdu_mul_array #(
  parameter int AW = 32,
  parameter int BW = 16,
  localparam int PW = AW + BW + 2
) (
  input  logic [AW-1:0]        a_i,
  input  logic                 a_sgn_i,
  input  logic [BW-1:0]        b_i,
  input  logic                 b_sgn_i,
  output logic signed [PW-1:0] prod_o
);

  logic signed [AW:0] ax;
  logic signed [BW:0] bx;

  always_comb begin
    ax     = {a_sgn_i & a_i[AW-1], a_i};
    bx     = {b_sgn_i & b_i[BW-1], b_i};
    prod_o = ax * bx;
  end

endmodule

// File: rtl/mdu_div_iter.sv
// Restoring divider on magnitudes with early entry past leading zeros.
module mdu_div_iter
  import mdu_pkg::*;
#(
  parameter int W      = 32,
  parameter int MIN_IT = 9,
  localparam int CW    = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  localparam logic [CW-1:0] W_C   = CW'(W);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_IT);

  dv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d, dvs_q, dvs_d;
  logic          negq_q, negq_d, negr_q, negr_d;
  logic          ld_en;

  logic [W-1:0]  mag_a, mag_b;
  logic [CW-1:0] len_a, iters;
  logic [W+1:0]  diff;
  logic          ge;

  // operand preparation for the load cycle
  always_comb begin
    mag_a = (sgn_i && a_i[W-1]) ? -a_i : a_i;
    mag_b = (sgn_i && b_i[W-1]) ? -b_i : b_i;
    len_a = '0;
    for (int i = 0; i < W; i++) begin
      if (mag_a[i]) len_a = CW'(i + 1);
    end
    iters = (len_a < MIN_C) ? MIN_C : len_a;
  end

  // one restoring step
  always_comb begin
    diff = {1'b0, rem_q, quo_q[W-1]} - {2'b00, dvs_q};
    ge   = ~diff[W+1];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    ld_en   = 1'b0;
    unique case (state_q)
      DV_IDLE: begin
        if (start_i) begin
          ld_en   = 1'b1;
          state_d = DV_RUN;
          cnt_d   = iters;
          quo_d   = mag_a << (W_C - iters);
          rem_d   = '0;
          dvs_d   = mag_b;
          negq_d  = sgn_i & (a_i[W-1] ^ b_i[W-1]);
          negr_d  = sgn_i & a_i[W-1];
        end
      end
      DV_RUN: begin
        ld_en = 1'b1;
        quo_d = {quo_q[W-2:0], ge};
        rem_d = ge ? diff[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = DV_FIX;
      end
      DV_FIX:  state_d = DV_IDLE;
      default: state_d = DV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_en) begin
        cnt_q  <= cnt_d;
        quo_q  <= quo_d;
        rem_q  <= rem_d;
        dvs_q  <= dvs_d;
        negq_q <= negq_d;
        negr_q <= negr_d;
      end
    end
  end

  always_comb begin
    busy_o = (state_q != DV_IDLE);
    fin_o  = (state_q == DV_FIX);
    quo_o  = negq_q ? -quo_q : quo_q;
    rem_o  = negr_q ? -rem_q : rem_q;
  end

endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
  import mdu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int DIV_MIN_ITER = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);

  localparam int HALF = XLEN / 2;
  localparam int PW   = XLEN + HALF + 2;
  localparam int RW   = 2 * XLEN;

  // second-pass state for wide multiplies
  logic            wide_q, wide_d;
  logic [XLEN-1:0] a_q;
  logic [HALF-1:0] bh_q;
  logic            sgn_q;
  logic [RW-1:0]   acc_q;
  logic            ld_en;

  // result registers
  logic [RW-1:0]   res_q, res_d;
  logic            res_en;
  logic            done_q, done_d;

  logic            accept, is_div, sgn, narrow;
  logic [XLEN-1:0] arr_a;
  logic            arr_a_sgn, arr_b_sgn;
  logic [HALF-1:0] arr_b;
  logic signed [PW-1:0] prod;
  logic [RW-1:0]   prod_ext;

  logic            div_busy, div_fin;
  logic [XLEN-1:0] div_quo, div_rem;

  always_comb begin
    busy_o = wide_q | div_busy;
    accept = start_i & ~busy_o;
    is_div = op_i[1];
    sgn    = ~op_i[0];
    narrow = sgn ? (opb_i[XLEN-1:HALF] == {HALF{opb_i[HALF-1]}})
                 : (opb_i[XLEN-1:HALF] == '0);
    if (wide_q) begin
      arr_a     = a_q;
      arr_a_sgn = sgn_q;
      arr_b     = bh_q;
      arr_b_sgn = sgn_q;
    end else begin
      arr_a     = opa_i;
      arr_a_sgn = sgn;
      arr_b     = opb_i[HALF-1:0];
      arr_b_sgn = sgn & narrow;
    end
  end

  mdu_mul_array #(.AW(XLEN), .BW(HALF)) u_array (
    .a_i     (arr_a),
    .a_sgn_i (arr_a_sgn),
    .b_i     (arr_b),
    .b_sgn_i (arr_b_sgn),
    .prod_o  (prod)
  );

  assign prod_ext = {{(RW - PW){prod[PW-1]}}, prod};

  mdu_div_iter #(.W(XLEN), .MIN_IT(DIV_MIN_ITER)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept & is_div),
    .sgn_i   (sgn),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .busy_o  (div_busy),
    .fin_o   (div_fin),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  // next-state
  always_comb begin
    wide_d = wide_q;
    ld_en  = 1'b0;
    res_en = 1'b0;
    res_d  = res_q;
    done_d = 1'b0;
    if (wide_q) begin
      res_en = 1'b1;
      res_d  = acc_q + (prod_ext << HALF);
      done_d = 1'b1;
      wide_d = 1'b0;
    end else if (div_fin) begin
      res_en = 1'b1;
      res_d  = {div_rem, div_quo};
      done_d = 1'b1;
    end else if (accept && !is_div) begin
      if (narrow) begin
        res_en = 1'b1;
        res_d  = prod_ext;
        done_d = 1'b1;
      end else begin
        ld_en  = 1'b1;
        wide_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      a_q    <= '0;
      bh_q   <= '0;
      sgn_q  <= 1'b0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      wide_q <= wide_d;
      done_q <= done_d;
      if (ld_en) begin
        a_q   <= opa_i;
        bh_q  <= opb_i[XLEN-1:HALF];
        sgn_q <= sgn;
        acc_q <= prod_ext;
      end
      if (res_en) res_q <= res_d;
    end
  end

  assign done_o = done_q;
  assign hi_o   = res_q[RW-1:XLEN];
  assign lo_o   = res_q[XLEN-1:0];

endmodule

// File: rtl/mdu_iter_chk.sv
module mdu_iter_chk #(
  parameter int XLEN         = 32,
  parameter int DIV_MIN_ITER = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [1:0]      op_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] hi_o,
  input logic [XLEN-1:0] lo_o
);

  localparam int HALF = XLEN / 2;
  localparam int LW   = 8;

  logic          acc_mul, acc_div, fits;
  logic [XLEN-1:0] mag;
  logic [LW-1:0] lat;
  logic          act_q;
  logic [LW-1:0] cnt_q, exp_q;

  always_comb begin
    acc_mul = start_i && !busy_o && !op_i[1];
    acc_div = start_i && !busy_o && op_i[1];
    fits    = op_i[0] ? (opb_i[XLEN-1:HALF] == '0)
                      : (opb_i[XLEN-1:HALF] == {HALF{opb_i[HALF-1]}});
    mag     = (!op_i[0] && opa_i[XLEN-1]) ? -opa_i : opa_i;
    lat     = LW'(DIV_MIN_ITER);
    for (int i = DIV_MIN_ITER; i < XLEN; i++) begin
      if (mag[i]) lat = LW'(i + 1);
    end
    lat = lat + LW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      if (act_q) cnt_q <= cnt_q + 1'b1;
      if (act_q && cnt_q == exp_q) act_q <= 1'b0;
      if (acc_div) begin
        act_q <= 1'b1;
        cnt_q <= LW'(1);
        exp_q <= lat;
      end
    end
  end

  AST_NARROW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul && fits |=> done_o && !busy_o);                         // R2
  AST_WIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul && !fits |=> busy_o && !done_o);                         // R3
  AST_WIDE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mul && !fits |-> ##2 done_o);                                // R3
  AST_DIV_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && cnt_q < exp_q |-> busy_o && !done_o);                   // R6
  AST_DIV_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && cnt_q == exp_q |-> done_o && !busy_o);                  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                             // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({hi_o, lo_o}));                              // R9

endmodule

bind mdu_iter mdu_iter_chk #(.XLEN(XLEN), .DIV_MIN_ITER(DIV_MIN_ITER)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/mdu_iter_test.sv
`timescale 1ns/1ps
module mdu_iter_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdu_iter uut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i),
    .opa_i (opa_i), .opb_i (opb_i), .busy_o (busy_o), .done_o (done_o),
    .hi_o (hi_o), .lo_o (lo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mul(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    longint sa, sb;
    if (op == 2'd0) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    return {32'd0, a} * {32'd0, b};
  endfunction

  function automatic logic [63:0] exp_div(input logic [1:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    longint sa, sb, q, r;
    if (op == 2'd2) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q  = sa / sb;
      r  = sa - q * sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  function automatic int exp_lat(input logic [1:0] op, input logic [31:0] a);
    logic [31:0] m;
    int n;
    m = (op == 2'd2 && a[31]) ? (~a + 32'd1) : a;
    n = 0;
    for (int i = 0; i < 32; i++) if (m[i]) n = i + 1;
    return 2 + ((n > 9) ? n : 9);
  endfunction

  // issue one request and wait for done; checks busy on the way (R6)
  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                        output int lat);
    bit busy_ok;
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    busy_ok = 1'b1;
    while (!done_o && lat < 60) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk(busy_ok || lat == 1, "R6 busy during operation", 64'(busy_ok), 64'd1);
    chk(!busy_o, "R6 busy low in done cycle", 64'(busy_o), 64'd0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o, "R10 reset flags", {busy_o, done_o}, 64'd0);
    chk({hi_o, lo_o} == 64'd0, "R10 reset result", {hi_o, lo_o}, 64'd0);
  endtask

  task automatic t_mul(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int exp_l);
    int lat;
    run_op(op, a, b, lat);
    chk(lat == exp_l, (exp_l == 1) ? "R2 narrow latency" : "R3 wide latency",
        64'(lat), 64'(exp_l));
    chk({hi_o, lo_o} == exp_mul(op, a, b), "R1 product", {hi_o, lo_o}, exp_mul(op, a, b));
  endtask

  task automatic t_div(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    int lat;
    run_op(op, a, b, lat);
    chk(lat == exp_lat(op, a), "R5 divide latency", 64'(lat), 64'(exp_lat(op, a)));
    chk({hi_o, lo_o} == exp_div(op, a, b), "R4 quotient/remainder",
        {hi_o, lo_o}, exp_div(op, a, b));
  endtask

  // three narrow multiplies started on consecutive cycles (R2)
  task automatic t_back_to_back();
    logic [31:0] av[3] = '{32'h1234_5678, 32'hFFFF_FFFB, 32'h0000_0101};
    logic [31:0] bv[3] = '{32'h0000_FFFF, 32'h0000_0007, 32'hFFFF_8000};
    logic [1:0]  ov[3] = '{2'd1, 2'd0, 2'd0};
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      start_i = 1'b1; op_i = ov[i]; opa_i = av[i]; opb_i = bv[i];
      @(negedge clk);
      chk(done_o && !busy_o, "R2 done every cycle", {busy_o, done_o}, 64'd1);
      chk({hi_o, lo_o} == exp_mul(ov[i], av[i], bv[i]), "R2 back-to-back product",
          {hi_o, lo_o}, exp_mul(ov[i], av[i], bv[i]));
    end
    start_i = 1'b0;
  endtask

  // start while busy must be dropped (R7)
  task automatic t_ignore(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input int exp_l);
    int lat;
    int extra;
    logic [63:0] e;
    e = op[1] ? exp_div(op, a, b) : exp_mul(op, a, b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    op_i = 2'd1; opa_i = 32'hDEAD_BEEF; opb_i = 32'h7777_0001;  // stays high while busy
    lat = 1;
    while (!done_o && lat < 60) begin
      @(negedge clk);
      lat++;
      if (lat == exp_l - 1) start_i = 1'b0;
    end
    start_i = 1'b0;
    chk(lat == exp_l, "R7 latency unaffected", 64'(lat), 64'(exp_l));
    chk({hi_o, lo_o} == e, "R7 result unaffected", {hi_o, lo_o}, e);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done_o) extra++;
    end
    chk(extra == 0, "R7 no extra done", 64'(extra), 64'd0);
  endtask

  task automatic t_div_zero();
    int lat;
    run_op(2'd3, 32'd12345, 32'd0, lat);
    chk(lat == exp_lat(2'd3, 32'd12345), "R8 zero-divisor latency", 64'(lat), 64'd16);
    t_div(2'd3, 32'd1000, 32'd9);
    chk(lo_o == 32'd111 && hi_o == 32'd1, "R8 next op after zero divisor",
        {hi_o, lo_o}, {32'd1, 32'd111});
  endtask

  task automatic t_hold();
    logic [63:0] snap;
    int lat;
    run_op(2'd1, 32'hAAAA_5555, 32'h0001_0003, lat);
    snap = {hi_o, lo_o};
    @(negedge clk);
    chk(!done_o, "R9 done is a single pulse", 64'(done_o), 64'd0);
    repeat (5) @(negedge clk);
    chk({hi_o, lo_o} == snap, "R9 result holds", {hi_o, lo_o}, snap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_mul(2'd1, 32'h1234_5678, 32'h0000_FFFF, 1);   // unsigned narrow
    t_mul(2'd0, 32'h7FFF_FFFF, 32'hFFFF_8000, 1);   // signed -32768 narrow
    t_mul(2'd0, 32'hFFFF_FFFB, 32'h0000_0007, 1);
    t_mul(2'd0, 32'h0000_0005, 32'h0000_FFFF, 2);   // signed, needs two passes
    t_mul(2'd0, 32'hFFFF_FFFD, 32'h1234_5678, 2);
    t_mul(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
    t_mul(2'd0, 32'h8000_0000, 32'h8000_0000, 2);
    t_back_to_back();
    t_div(2'd3, 32'hFFFF_FFFF, 32'd7);
    t_div(2'd3, 32'd100, 32'd7);
    t_div(2'd3, 32'h0000_03FF, 32'd3);
    t_div(2'd2, 32'hFFFF_FF9C, 32'd7);              // -100 / 7
    t_div(2'd2, 32'd100, 32'hFFFF_FFF9);            // 100 / -7
    t_div(2'd2, 32'hFFFF_FF9C, 32'hFFFF_FFF9);      // -100 / -7
    t_div(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    t_div(2'd2, 32'hFFFF_FFFF, 32'd3);
    t_div(2'd3, 32'd0, 32'd5);
    t_div(2'd2, 32'h00FF_FFFF, 32'hFFFF_FF00);
    t_ignore(2'd0, 32'h0001_0000, 32'h0002_0001, 2);
    t_ignore(2'd3, 32'h00AB_CDEF, 32'd13, exp_lat(2'd3, 32'h00AB_CDEF));
    t_div_zero();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule